// File: doc/BRIEF.md
# Repeated Word-Copy Sequencer

This block moves a run of data units from one region of memory to another, one unit at a time, under the control of a small microcoded sequencer. A caller loads a repeat count, a source pointer and a destination pointer and pulses `start`. Each pass of the loop opens with a head state. That state decrements the count and branches on whether the count was nonzero before the decrement. If it was, the engine runs through six further microstates:

1. copy the source pointer into an address register;
2. step the source pointer;
3. read memory and wait for `mem_ready`;
4. copy the destination pointer into the address register;
5. step the destination pointer;
6. write the captured data and wait for `mem_ready`.

Control then returns to the head state.

A single increment/decrement unit serves all three registers. It can pass a value through, add one or subtract one, and the microword selects which register feeds it. The pass-through mode is how the pointers reach the address register. Every address presented to memory has its lowest bit cleared. Pointers advance by one unit per pass and wrap at the 16-bit boundary, so an even pointer and the odd pointer after it touch the same word. When the count runs out, the engine raises `done` for one cycle and returns to idle. While a copy is running, `start` is ignored.

Top module: `rep_copy_engine`

## Requirements
- R1: After reset is released, and after a reset applied in the middle of a copy, `mem_req` and `done` are low and the engine is idle, ready to accept `start`.
- R2: A start with a count of zero makes no memory access and raises `done` on the first cycle after the start is taken.
- R3: A start with count N performs exactly N reads and N writes. Pass k (k = 0..N-1) reads the word at source pointer + k and then writes that value to the word at destination pointer + k, in that order, so overlapping regions behave as a forward copy.
- R4: Every address driven while `mem_req` is high has bit 0 equal to 0. The word used is the pointer value with bit 0 cleared.
- R5: The source and destination pointers each advance by exactly one per pass and wrap modulo 2^16 (0xFFFF is followed by 0x0000).
- R6: A read or write request, together with its `mem_addr`, `mem_we` and `mem_wdata`, stays unchanged until `mem_ready` is seen high. Read data is captured only in the cycle in which `mem_ready` is high.
- R7: `done` is high for exactly one cycle. It rises N*(7+2L)+1 cycles after the clock edge that takes `start`, where L is the number of wait cycles before each `mem_ready`.
- R8: A `start` pulse during a copy, even with different initial values, has no effect on that copy's accesses, data or completion time.
- R9: `mem_we` is high only on write requests, and `mem_wdata` then carries the value captured by the preceding read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy; sampled only while idle |
| cnt_init | input | 16 | Repeat count loaded at start |
| src_init | input | 16 | Source pointer loaded at start |
| dst_init | input | 16 | Destination pointer loaded at start |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word-aligned access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while `mem_ready` is high |
| mem_ready | input | 1 | Memory completes the current access |

## Verification
The case that is hardest to reach from the ports is a `start` arriving while the engine is in the middle of a stretched read or write. The request is still pending, and a wrongly accepted start would silently reload the pointers. The bench therefore pulses `start` with different initial values a few cycles into a copy whose memory responder holds back `mem_ready`. It then compares the whole memory image and the completion time with a copy that had no interference. Until it acknowledges, the responder drives junk on `mem_rdata`, so early capture shows up as corrupted data. The vectors include odd pointers, regions that overlap, and pointers that wrap past 0xFFFF.

// File: rtl/rce_pkg.sv
package rce_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_TEST, S_SRCA, S_SRCI, S_RD, S_DSTA, S_DSTI, S_WR
  } state_e;

  typedef enum logic [1:0] {ID_PASS, ID_INC, ID_DEC} step_e;

  typedef enum logic [1:0] {RS_CNT, RS_SRC, RS_DST} rsel_e;

  typedef enum logic [1:0] {BR_START, BR_ALWAYS, BR_READY, BR_REPEAT} br_e;

  typedef struct packed {
    br_e    br;
    state_e nxt_t;
    state_e nxt_f;
    rsel_e  sel;
    step_e  step;
    logic   rf_we;
    logic   mar_ld;
    logic   mdr_ld;
    logic   req;
    logic   we;
  } uword_t;

  // Microcode store: one word per state.
  function automatic uword_t ucode(input state_e s);
    uword_t u;
    u = '0;
    u.br    = BR_ALWAYS;
    u.nxt_t = S_IDLE;
    u.nxt_f = S_IDLE;
    u.sel   = RS_CNT;
    u.step  = ID_PASS;
    case (s)
      S_IDLE: begin
        u.br = BR_START; u.nxt_t = S_TEST; u.nxt_f = S_IDLE;
      end
      S_TEST: begin
        u.br = BR_REPEAT; u.nxt_t = S_SRCA; u.nxt_f = S_IDLE;
        u.sel = RS_CNT; u.step = ID_DEC; u.rf_we = 1'b1;
      end
      S_SRCA: begin
        u.nxt_t = S_SRCI; u.sel = RS_SRC; u.step = ID_PASS; u.mar_ld = 1'b1;
      end
      S_SRCI: begin
        u.nxt_t = S_RD; u.sel = RS_SRC; u.step = ID_INC; u.rf_we = 1'b1;
      end
      S_RD: begin
        u.br = BR_READY; u.nxt_t = S_DSTA; u.nxt_f = S_RD;
        u.req = 1'b1; u.mdr_ld = 1'b1;
      end
      S_DSTA: begin
        u.nxt_t = S_DSTI; u.sel = RS_DST; u.step = ID_PASS; u.mar_ld = 1'b1;
      end
      S_DSTI: begin
        u.nxt_t = S_WR; u.sel = RS_DST; u.step = ID_INC; u.rf_we = 1'b1;
      end
      S_WR: begin
        u.br = BR_READY; u.nxt_t = S_TEST; u.nxt_f = S_WR;
        u.req = 1'b1; u.we = 1'b1;
      end
      default: u.nxt_t = S_IDLE;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/rce_incdec.sv
module rce_incdec
  import rce_pkg::*;
#(
  parameter int W = 16
) (
  input  rsel_e          sel_i,
  input  step_e          step_i,
  input  logic [W-1:0]   cnt_i,
  input  logic [W-1:0]   src_i,
  input  logic [W-1:0]   dst_i,
  output logic [W-1:0]   res_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] operand;

  always_comb begin
    case (sel_i)
      RS_SRC:  operand = src_i;
      RS_DST:  operand = dst_i;
      default: operand = cnt_i;
    endcase
  end

  always_comb begin
    case (step_i)
      ID_INC:  res_o = operand + ONE;
      ID_DEC:  res_o = operand - ONE;
      default: res_o = operand;
    endcase
  end

endmodule

// File: rtl/rce_regfile.sv
module rce_regfile
  import rce_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] cnt_init_i,
  input  logic [W-1:0] src_init_i,
  input  logic [W-1:0] dst_init_i,
  input  logic         we_i,
  input  rsel_e        sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] src_o,
  output logic [W-1:0] dst_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, src_q, dst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      src_q <= '0;
      dst_q <= '0;
    end else if (load_i) begin
      cnt_q <= cnt_init_i;
      src_q <= src_init_i;
      dst_q <= dst_init_i;
    end else if (we_i) begin
      case (sel_i)
        RS_SRC:  src_q <= wdata_i;
        RS_DST:  dst_q <= wdata_i;
        default: cnt_q <= wdata_i;
      endcase
    end
  end

  assign cnt_o = cnt_q;
  assign src_o = src_q;
  assign dst_o = dst_q;

  // R5: outside a load, pointers only ever move forward by one (with wrap)
  p_src_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_i) && !$stable(src_q)) |-> src_q == $past(src_q) + ONE);
  p_dst_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_i) && !$stable(dst_q)) |-> dst_q == $past(dst_q) + ONE);

endmodule

// File: rtl/rce_useq.sv
module rce_useq
  import rce_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  logic   ready_i,
  input  logic   repeat_i,
  output state_e state_o,
  output uword_t uw_o
);
  state_e state_q, state_d;
  uword_t uw;
  logic   cond;

  assign uw = ucode(state_q);

  always_comb begin
    case (uw.br)
      BR_START:  cond = start_i;
      BR_READY:  cond = ready_i;
      BR_REPEAT: cond = repeat_i;
      default:   cond = 1'b1;
    endcase
    state_d = cond ? uw.nxt_t : uw.nxt_f;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

  assign state_o = state_q;
  assign uw_o    = uw;

  // R2: the only way back to idle is a failed repeat test at the loop head
  p_exit_from_test_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && state_q == S_IDLE && $past(state_q) != S_IDLE)
      |-> ($past(state_q) == S_TEST && !$past(repeat_i)));

endmodule

// File: rtl/rep_copy_engine.sv
module rep_copy_engine
  import rce_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] cnt_init,
  input  logic [W-1:0] src_init,
  input  logic [W-1:0] dst_init,
  output logic         done,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ready
);
  state_e       state;
  uword_t       uw;
  logic [W-1:0] cnt, src, dst, step_res;
  logic [W-1:0] mar_q, mdr_q;
  logic         done_q, rep, load;

  assign rep  = (cnt != '0);
  assign load = (state == S_IDLE) && start;

  rce_useq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .ready_i  (mem_ready),
    .repeat_i (rep),
    .state_o  (state),
    .uw_o     (uw)
  );

  rce_incdec #(.W(W)) u_incdec (
    .sel_i  (uw.sel),
    .step_i (uw.step),
    .cnt_i  (cnt),
    .src_i  (src),
    .dst_i  (dst),
    .res_o  (step_res)
  );

  rce_regfile #(.W(W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .cnt_init_i (cnt_init),
    .src_init_i (src_init),
    .dst_init_i (dst_init),
    .we_i       (uw.rf_we),
    .sel_i      (uw.sel),
    .wdata_i    (step_res),
    .cnt_o      (cnt),
    .src_o      (src),
    .dst_o      (dst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q  <= '0;
      mdr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (uw.mar_ld) mar_q <= step_res;
      if (uw.mdr_ld && mem_ready) mdr_q <= mem_rdata;
      done_q <= (state == S_TEST) && !rep;
    end
  end

  assign done      = done_q;
  assign mem_req   = uw.req;
  assign mem_we    = uw.we;
  assign mem_addr  = {mar_q[W-1:1], 1'b0};
  assign mem_wdata = mdr_q;

  // R6: a pending access holds all its fields until acknowledged
  p_hold_until_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));
  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2: completion never overlaps a memory access
  p_done_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);
  // R9: a write is always a request
  p_we_in_req_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

endmodule

// File: tb/rep_copy_engine_bench.sv
`timescale 1ns/1ps
module rep_copy_engine_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] cnt_i = '0, src_i = '0, dst_i = '0;
  logic        done, mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = 16'hDEAD;
  logic        mem_ready = 1'b0;

  always #2 clk = ~clk;

  rep_copy_engine u_rep_copy_engine (
    .clk(clk), .rst(rst), .start(start),
    .cnt_init(cnt_i), .src_init(src_i), .dst_init(dst_i),
    .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  // {count, src, dst, wait cycles}
  localparam logic [51:0] VECS [7] = '{
    {16'd1, 16'h0020, 16'h0100, 4'd0},
    {16'd5, 16'h0040, 16'h0140, 4'd2},
    {16'd4, 16'h0031, 16'h0181, 4'd1},
    {16'd3, 16'hFFFE, 16'h01C0, 4'd0},
    {16'd6, 16'h0010, 16'h0013, 4'd3},
    {16'd0, 16'h0050, 16'h0150, 4'd0},
    {16'd2, 16'h0060, 16'hFFFF, 4'd1}
  };

  logic [15:0] mem    [256];
  logic [15:0] shadow [256];
  int lat_cfg = 0, rd_cnt = 0, wr_cnt = 0, odd_cnt = 0, wait_c = 0;
  int nchk = 0, nfail = 0;

  function automatic logic [7:0] idx(input logic [15:0] a);
    return a[8:1];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory responder: ready after lat_cfg wait cycles, junk data until then
  initial forever begin
    @(negedge clk);
    if (mem_req) begin
      if (wait_c >= lat_cfg) begin
        mem_ready = 1'b1;
        if (mem_addr[0]) odd_cnt++;
        if (mem_we) begin
          mem[idx(mem_addr)] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = mem[idx(mem_addr)];
          rd_cnt++;
        end
        wait_c = 0;
      end else begin
        mem_ready = 1'b0;
        mem_rdata = 16'hDEAD;
        wait_c++;
      end
    end else begin
      mem_ready = 1'b0;
      mem_rdata = 16'hDEAD;
      wait_c = 0;
    end
  end

  task automatic run(input logic [15:0] n, input logic [15:0] s, input logic [15:0] d,
                     input int lat, input bit poke);
    int cyc;
    int exp_cyc;
    int mism;
    lat_cfg = lat;
    for (int i = 0; i < 256; i++) mem[i] = {8'(i), 8'(8'hA5 ^ 8'(i))};
    for (int i = 0; i < 256; i++) shadow[i] = mem[i];
    for (int k = 0; k < int'(n); k++)
      shadow[idx(16'(d + 16'(k)))] = shadow[idx(16'(s + 16'(k)))];
    rd_cnt = 0; wr_cnt = 0; odd_cnt = 0;
    exp_cyc = int'(n) * (7 + 2 * lat) + 1;
    @(negedge clk);
    start = 1'b1; cnt_i = n; src_i = s; dst_i = d;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin
        start = 1'b1; cnt_i = 16'd9; src_i = 16'h0090; dst_i = 16'h0190;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(cyc == exp_cyc, poke ? "R8 completion time" : "R7 completion time", cyc, exp_cyc);
    check(rd_cnt == int'(n), "R3 read count", rd_cnt, int'(n));
    check(wr_cnt == int'(n), "R3 write count", wr_cnt, int'(n));
    check(odd_cnt == 0, "R4 odd address", odd_cnt, 0);
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) mism++;
    check(mism == 0, "R3 R5 R6 R9 memory image", mism, 0);
    @(negedge clk);
    check(!done, "R7 done pulse width", done, 0);
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!mem_req, "R1 req after reset", mem_req, 0);
    check(!done, "R1 done after reset", done, 0);

    for (int v = 0; v < 7; v++)
      run(VECS[v][51:36], VECS[v][35:20], VECS[v][19:4], int'(VECS[v][3:0]), 1'b0);

    // R2: zero count, directed, with slow memory configured
    run(16'd0, 16'h0002, 16'h0102, 3, 1'b0);

    // R8: start pulses during a stretched copy are ignored
    run(16'd5, 16'h0070, 16'h0170, 3, 1'b1);

    // R1: reset in the middle of a copy
    lat_cfg = 2;
    @(negedge clk);
    start = 1'b1; cnt_i = 16'd8; src_i = 16'h0000; dst_i = 16'h0100;
    @(negedge clk);
    start = 1'b0;
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!mem_req, "R1 req after mid-copy reset", mem_req, 0);
    check(!done, "R1 done after mid-copy reset", done, 0);
    run(16'd2, 16'h0044, 16'h0088, 0, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule